// File: doc/BRIEF.md
# Multiplexed LCD Segment/Common Sequencer

This block sequences the drive of a multiplexed liquid-crystal panel with four common lines and forty segment lines. A 40-entry display memory holds four bits per segment, one bit per common. The sequencer steps through the commons of the selected duty. On every output line it presents a 2-bit level code that names the bias level to apply. The codes are digital; a ladder and analog drivers outside the block turn them into voltages. Each common slot has two halves of opposite polarity, so the mean voltage across every pixel is zero.

The duty is static, 1/2, 1/3 or 1/4, and the bias is 1/2 or 1/3. Both are loaded together with a display-enable bit and a pin-assignment field in a single configuration write. The same display-enable bit drives the output that powers the external bias divider. Segments 16 to 39 can be handed back to plain port use, in groups of mixed size. A pin in port mode forwards its port data bit. After reset every one of these pins is in port mode.

Top module: `lcd_mux_seq`

## Requirements
- R1: After reset, `ladder_en_o` is 0, every common and segment code is 0 (supply level), every assignable pin is in port mode (`port_o` equals `port_data_i`), duty is static and bias is 1/2.
- R2: While enabled, each `tick_i` flips the polarity half. The common index advances after half 1, and wraps from N-1 to 0 for 1/N duty (duty field 0 = static, 1 = 1/2, 2 = 1/3, 3 = 1/4). Without a tick the codes hold.
- R3: The active common reads code 0 (supply) in half 0 and code 3 (lowest) in half 1.
- R4: Every other common, including those beyond the selected duty, reads the unselected level. With 1/3 bias this is code 2 in half 0 and code 1 in half 1. With 1/2 bias it is code 1 in both halves.
- R5: A segment whose memory bit for the active common is 1 reads code 3 in half 0 and code 0 in half 1.
- R6: In 1/2, 1/3 and 1/4 duty, a segment whose bit is 0 reads code 1 in half 0 and code 2 in half 1 under 1/3 bias, and code 1 in both halves under 1/2 bias.
- R7: In static duty, common 0 is always the active one, and an off segment follows it (code 0 in half 0, code 3 in half 1).
- R8: With the display disabled, all codes are 0, `ladder_en_o` is 0, ticks are ignored and the sequencer stays at common 0, half 0.
- R9: The pin-assignment field maps as follows (1 = segment, 0 = port). Bits 0 to 3 select segments 20 to 23 one by one. Bit 4 selects segments 16 to 19. Bit 5 selects segments 24 to 31. Bit 6 selects segments 32 to 39. A pin in port mode has segment code 0 and drives `port_o[s-16] = port_data_i[s-16]`. A pin in segment mode drives `port_o` bit 0. Segments 0 to 15 are always segments.
- R10: A memory write at address s < 40 sets the bit for common c from bit c of `mem_wdata_i`. Writes to addresses 40 to 63 change nothing.
- R11: Every configuration write returns the sequencer to common 0, half 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Half-phase advance strobe from the prescaler |
| cfg_we_i | input | 1 | Load all configuration fields |
| cfg_duty_i | input | 2 | Duty: 0 static, 1 1/2, 2 1/3, 3 1/4 |
| cfg_bias3_i | input | 1 | 1 selects 1/3 bias, 0 selects 1/2 bias |
| cfg_disp_en_i | input | 1 | Display and bias divider enable |
| cfg_seg_sel_i | input | 7 | Pin assignment field, 1 = segment |
| mem_we_i | input | 1 | Display memory write strobe |
| mem_addr_i | input | 6 | Display memory segment address |
| mem_wdata_i | input | 4 | One bit per common |
| port_data_i | input | 24 | Port data for pins 16 to 39 |
| com_code_o | output | 8 | Level code per common, 2 bits each |
| seg_code_o | output | 80 | Level code per segment, 2 bits each |
| port_o | output | 24 | Port value for pins 16 to 39 |
| ladder_en_o | output | 1 | Bias divider current enable |

## Verification
On every cycle the assertions check four things. A disabled display shows only supply codes. An enabled display has exactly one common at an extreme level. A pin that is driving port data carries a zero segment code. The common codes change on a tick and stay put without one. The exact level values depend on duty, bias, half and memory contents, so only the bench's sweeps can show them: the wrap point of each duty, the pin-group mapping, ignored out-of-range memory writes and the restart on a configuration write.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  typedef enum logic [1:0] {
    LV_TOP  = 2'd0,
    LV_HMID = 2'd1,
    LV_LMID = 2'd2,
    LV_BOT  = 2'd3
  } lvl_e;

  localparam int unsigned SEL_W     = 7;
  localparam int unsigned PORT_BASE = 16;

  // pin-assignment bit that governs a segment (only valid for seg >= PORT_BASE)
  function automatic int unsigned sel_bit_of(input int unsigned seg);
    if (seg < 20)      return 4;
    else if (seg < 24) return seg - 20;
    else if (seg < 32) return 5;
    else               return 6;
  endfunction
endpackage

// File: rtl/lcd_phase_ctr.sv
module lcd_phase_ctr #(
  parameter int unsigned NUM_COM = 4,
  localparam int unsigned IW = $clog2(NUM_COM)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [IW-1:0] last_i,
  output logic [IW-1:0] idx_o,
  output logic          half_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o  <= '0;
      half_o <= 1'b0;
    end else if (clr_i || !run_i) begin
      idx_o  <= '0;
      half_o <= 1'b0;
    end else if (tick_i) begin
      half_o <= ~half_o;
      if (half_o) idx_o <= (idx_o >= last_i) ? '0 : idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_disp_mem.sv
module lcd_disp_mem #(
  parameter int unsigned NUM_COM = 4,
  parameter int unsigned NUM_SEG = 40,
  localparam int unsigned IW = $clog2(NUM_COM),
  localparam int unsigned AW = $clog2(NUM_SEG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [NUM_COM-1:0] wdata_i,
  input  logic [IW-1:0]      idx_i,
  output logic [NUM_SEG-1:0] col_o
);
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_ent
    localparam logic [AW-1:0] ADDR = AW'(s);
    logic [NUM_COM-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       ent_q <= '0;
      else if (we_i && addr_i == ADDR)   ent_q <= wdata_i;
    end
    assign col_o[s] = ent_q[idx_i];
  end
endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
  import lcd_seq_pkg::*;
#(
  parameter int unsigned NUM_COM = 4,
  parameter int unsigned NUM_SEG = 40,
  localparam int unsigned IW = $clog2(NUM_COM)
) (
  input  logic [IW-1:0]        idx_i,
  input  logic                 half_i,
  input  logic                 static_i,
  input  logic                 bias3_i,
  input  logic                 en_i,
  input  logic [NUM_SEG-1:0]   col_i,
  input  logic [NUM_SEG-1:0]   seg_mode_i,
  output logic [2*NUM_COM-1:0] com_o,
  output logic [2*NUM_SEG-1:0] seg_o
);
  lvl_e com_unsel, seg_off_mux, sel_lv, on_lv;

  always_comb begin
    sel_lv      = half_i ? LV_BOT : LV_TOP;
    on_lv       = half_i ? LV_TOP : LV_BOT;
    com_unsel   = bias3_i ? (half_i ? LV_HMID : LV_LMID) : LV_HMID;
    seg_off_mux = bias3_i ? (half_i ? LV_LMID : LV_HMID) : LV_HMID;
  end

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    localparam logic [IW-1:0] CI = IW'(c);
    lvl_e lv;
    always_comb begin
      if (!en_i)            lv = LV_TOP;
      else if (idx_i == CI) lv = sel_lv;
      else                  lv = com_unsel;
    end
    assign com_o[2*c +: 2] = lv;
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    lvl_e lv;
    always_comb begin
      if (!en_i || !seg_mode_i[s]) lv = LV_TOP;
      else if (col_i[s])           lv = on_lv;
      else if (static_i)           lv = sel_lv;
      else                         lv = seg_off_mux;
    end
    assign seg_o[2*s +: 2] = lv;
  end
endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq
  import lcd_seq_pkg::*;
#(
  parameter int unsigned NUM_COM = 4,
  parameter int unsigned NUM_SEG = 40,
  localparam int unsigned IW = $clog2(NUM_COM),
  localparam int unsigned AW = $clog2(NUM_SEG),
  localparam int unsigned NPORT = NUM_SEG - PORT_BASE
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 cfg_we_i,
  input  logic [IW-1:0]        cfg_duty_i,
  input  logic                 cfg_bias3_i,
  input  logic                 cfg_disp_en_i,
  input  logic [SEL_W-1:0]     cfg_seg_sel_i,
  input  logic                 mem_we_i,
  input  logic [AW-1:0]        mem_addr_i,
  input  logic [NUM_COM-1:0]   mem_wdata_i,
  input  logic [NPORT-1:0]     port_data_i,
  output logic [2*NUM_COM-1:0] com_code_o,
  output logic [2*NUM_SEG-1:0] seg_code_o,
  output logic [NPORT-1:0]     port_o,
  output logic                 ladder_en_o
);
  logic [IW-1:0]      duty_q;
  logic               bias3_q, en_q;
  logic [SEL_W-1:0]   sel_q;
  logic [IW-1:0]      idx;
  logic               half;
  logic [NUM_SEG-1:0] col, seg_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q  <= '0;
      bias3_q <= 1'b0;
      en_q    <= 1'b0;
      sel_q   <= '0;
    end else if (cfg_we_i) begin
      duty_q  <= cfg_duty_i;
      bias3_q <= cfg_bias3_i;
      en_q    <= cfg_disp_en_i;
      sel_q   <= cfg_seg_sel_i;
    end
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_mode
    if (s < PORT_BASE) begin : g_fixed
      assign seg_mode[s] = 1'b1;
    end else begin : g_assign
      localparam int unsigned B = sel_bit_of(s);
      assign seg_mode[s]          = sel_q[B];
      assign port_o[s-PORT_BASE]  = ~sel_q[B] & port_data_i[s-PORT_BASE];
    end
  end

  lcd_phase_ctr #(.NUM_COM(NUM_COM)) u_ctr (
    .clk_i, .rst_ni,
    .run_i  (en_q),
    .clr_i  (cfg_we_i),
    .tick_i,
    .last_i (duty_q),
    .idx_o  (idx),
    .half_o (half)
  );

  lcd_disp_mem #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_mem (
    .clk_i, .rst_ni,
    .we_i    (mem_we_i),
    .addr_i  (mem_addr_i),
    .wdata_i (mem_wdata_i),
    .idx_i   (idx),
    .col_o   (col)
  );

  lcd_level_map #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_map (
    .idx_i      (idx),
    .half_i     (half),
    .static_i   (duty_q == '0),
    .bias3_i    (bias3_q),
    .en_i       (en_q),
    .col_i      (col),
    .seg_mode_i (seg_mode),
    .com_o      (com_code_o),
    .seg_o      (seg_code_o)
  );

  assign ladder_en_o = en_q;
endmodule

// File: rtl/lcd_mux_seq_chk.sv
module lcd_mux_seq_chk #(
  parameter int unsigned NUM_COM = 4,
  parameter int unsigned NUM_SEG = 40,
  parameter int unsigned NPORT   = 24
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tick_i,
  input logic                 cfg_we_i,
  input logic [2*NUM_COM-1:0] com_code_o,
  input logic [2*NUM_SEG-1:0] seg_code_o,
  input logic [NPORT-1:0]     port_o,
  input logic                 ladder_en_o
);
  int unsigned n_ext;
  logic        port_clash;

  always_comb begin
    n_ext = 0;
    for (int c = 0; c < NUM_COM; c++)
      if (com_code_o[2*c +: 2] == 2'd0 || com_code_o[2*c +: 2] == 2'd3) n_ext++;
    port_clash = 1'b0;
    for (int k = 0; k < NPORT; k++)
      if (port_o[k] && seg_code_o[2*(k+NUM_SEG-NPORT) +: 2] != 2'd0) port_clash = 1'b1;
  end

  AST_OFF_SUPPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ladder_en_o |-> (com_code_o == '0 && seg_code_o == '0)); // R8
  AST_ONE_ACTIVE_COM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ladder_en_o |-> n_ext == 1); // R3
  AST_PORT_NO_SEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_clash); // R9
  AST_TICK_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ladder_en_o && tick_i && !cfg_we_i) |=> !$stable(com_code_o)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ladder_en_o && !tick_i && !cfg_we_i) |=> $stable(com_code_o)); // R2
endmodule

bind lcd_mux_seq lcd_mux_seq_chk #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .NPORT(NPORT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .cfg_we_i(cfg_we_i),
  .com_code_o(com_code_o), .seg_code_o(seg_code_o), .port_o(port_o),
  .ladder_en_o(ladder_en_o)
);

// File: tb/lcd_mux_seq_bench.sv
module lcd_mux_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_duty_i = '0;
  logic        cfg_bias3_i = 1'b0;
  logic        cfg_disp_en_i = 1'b0;
  logic [6:0]  cfg_seg_sel_i = '0;
  logic        mem_we_i = 1'b0;
  logic [5:0]  mem_addr_i = '0;
  logic [3:0]  mem_wdata_i = '0;
  logic [23:0] port_data_i = 24'hA5C3E1;
  logic [7:0]  com_code_o;
  logic [79:0] seg_code_o;
  logic [23:0] port_o;
  logic        ladder_en_o;

  int n_chk = 0, n_bad = 0;
  int e_idx = 0, e_half = 0, e_duty = 0, e_bias = 0, e_en = 0;
  logic [6:0] e_sel = '0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  lcd_mux_seq u_lcd_mux_seq (.*);

  function automatic logic [3:0] pat(input int s);
    return 4'((s * 5 + 9) % 16);
  endfunction

  function automatic bit is_seg(input int s, input logic [6:0] sel);
    if (s < 16) return 1;
    if (s < 20) return sel[4];
    if (s < 24) return sel[s-20];
    if (s < 32) return sel[5];
    return sel[6];
  endfunction

  function automatic logic [7:0] exp_com();
    logic [7:0] v = '0;
    for (int c = 0; c < 4; c++) begin
      logic [1:0] l;
      if (!e_en) l = 0;
      else if (c == e_idx) l = e_half ? 2'd3 : 2'd0;
      else l = e_bias ? (e_half ? 2'd1 : 2'd2) : 2'd1;
      v[2*c +: 2] = l;
    end
    return v;
  endfunction

  function automatic logic [79:0] exp_seg();
    logic [79:0] v = '0;
    for (int s = 0; s < 40; s++) begin
      logic [1:0] l;
      logic [3:0] p = pat(s);
      if (!e_en || !is_seg(s, e_sel)) l = 0;
      else if (p[e_idx]) l = e_half ? 2'd0 : 2'd3;
      else if (e_duty == 0) l = e_half ? 2'd3 : 2'd0;
      else l = e_bias ? (e_half ? 2'd2 : 2'd1) : 2'd1;
      v[2*s +: 2] = l;
    end
    return v;
  endfunction

  function automatic logic [23:0] exp_port();
    logic [23:0] v;
    for (int k = 0; k < 24; k++) v[k] = is_seg(k + 16, e_sel) ? 1'b0 : port_data_i[k];
    return v;
  endfunction

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic check(input string req);
    logic [7:0]  ec = exp_com();
    logic [79:0] es = exp_seg();
    logic [23:0] ep = exp_port();
    n_chk += 4;
    if (com_code_o !== ec) begin n_bad++; $display("FAIL %s com act=%h exp=%h", req, com_code_o, ec); end
    if (seg_code_o !== es) begin n_bad++; $display("FAIL %s seg act=%h exp=%h", req, seg_code_o, es); end
    if (port_o !== ep) begin n_bad++; $display("FAIL %s port act=%h exp=%h", req, port_o, ep); end
    if (ladder_en_o !== 1'(e_en)) begin n_bad++; $display("FAIL %s ladder act=%b exp=%0d", req, ladder_en_o, e_en); end
  endtask

  task automatic cfg(input int d, input int b, input int en, input logic [6:0] sel);
    cfg_duty_i = 2'(d); cfg_bias3_i = 1'(b); cfg_disp_en_i = 1'(en); cfg_seg_sel_i = sel;
    cfg_we_i = 1; step(); cfg_we_i = 0;
    e_duty = d; e_bias = b; e_en = en; e_sel = sel; e_idx = 0; e_half = 0;
  endtask

  task automatic tick();
    tick_i = 1; step(); tick_i = 0;
    if (e_en) begin
      if (e_half) begin e_half = 0; e_idx = (e_idx == e_duty) ? 0 : e_idx + 1; end
      else e_half = 1;
    end
  endtask

  task automatic memw(input int a, input logic [3:0] d);
    mem_addr_i = 6'(a); mem_wdata_i = d; mem_we_i = 1; step(); mem_we_i = 0;
  endtask

  initial begin
    repeat (3) step();
    check("R1 reset");
    rst_ni = 1; step();
    check("R1 after release");
    for (int s = 0; s < 40; s++) memw(s, pat(s));
    for (int a = 40; a < 64; a++) memw(a, 4'hF);
    tick(); check("R8 tick ignored while off");
    // duty x bias sweep, all pins as segments
    for (int d = 0; d < 4; d++)
      for (int b = 0; b < 2; b++) begin
        cfg(d, b, 1, 7'h7F);
        check("R11 R10 start");
        for (int t = 0; t < 4 * (d + 1) + 1; t++) begin
          tick();
          check(d == 0 ? "R7 static" : (b ? "R3 R4 R5 R6 bias3" : "R3 R4 R5 R6 bias2"));
          step(); check("R2 hold without tick");
        end
      end
    // restart on config write mid-frame
    cfg(3, 1, 1, 7'h7F);
    repeat (5) tick();
    check("R2 mid frame");
    cfg(3, 1, 1, 7'h7F);
    check("R11 restart");
    // pin assignment sweep
    for (int v = 0; v < 128; v++) begin
      port_data_i = 24'hA5C3E1 ^ 24'(v * 24'h01F3);
      cfg(3, 1, 1, 7'(v));
      check("R9 pin groups");
      tick(); check("R9 pin groups half1");
    end
    // display off with segments assigned
    cfg(2, 1, 0, 7'h55);
    check("R8 off");
    repeat (3) tick();
    check("R8 off ticks");
    cfg(2, 1, 1, 7'h55);
    check("R8 R11 re-enable");
    // rewrite memory live, then restore
    memw(7, 4'hF);
    n_chk++;
    if (seg_code_o[15:14] !== 2'd3) begin n_bad++; $display("FAIL R10 live write act=%0d exp=3", seg_code_o[15:14]); end
    memw(7, pat(7));
    check("R10 restore");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule